// File: doc/BRIEF.md
# Scan Chain Router and Serializer

This block takes parallel words written through a small register interface and shifts them out, least significant bit first, on one of eight selectable scan chain indices. Chains 0 to 3 are plain I/O configuration shift chains. Each of them gets only a serial data line and a serial clock, with no test-port protocol. Chain 7 is a bridge to an FPGA test access port. On that chain the block drives clock, mode select and data, and it captures the returning data bit so that software can read it back.

The bridge is gated by an external system-level enable, which is low after a cold reset. While the enable is low, the FPGA port follows its own external pins. An external override input tells the block that the FPGA port is reconfiguring the I/O chains itself. While it is high, the block keeps its I/O chain outputs quiet. Writes that cannot be honoured are dropped and raise a sticky error bit.

The registers are: configuration (address 0: chain select in bits [2:0], divider in bits [15:8]), data (address 1: a write starts a shift, a read returns the received word), mode-select word (address 2), and status (address 3: bit 0 busy, bit 1 error).

Top module: `scan_route_ser`

## Requirements
- R1: Only chain indices 0, 1, 2, 3 and 7 are connected. A data write while index 4, 5 or 6 is selected is dropped. It sets the error bit, and every chain output stays low.
- R2: A shift on chain k (0 to 3) toggles only io_tck[k] and drives only io_tdi[k]. It sends the DATA_W-bit word LSB first. The data changes only while the clock is low, so each bit is stable at the rising clock edge.
- R3: With bridge_en high and chain 7 selected, the block drives tap_tck, tap_tdi and tap_tms. tap_tms carries the mode-select word (address 2) LSB first, in step with the data bits.
- R4: With bridge_en low, tap_tck, tap_tms and tap_tdi follow ext_tck, ext_tms and ext_tdi. A data write with chain 7 selected is dropped and sets the error bit. ext_tdo always follows tap_tdo.
- R5: During a chain-7 shift, tap_tdo is sampled at each rising edge of tap_tck. After the shift, a read of address 1 returns the captured bits, with the first captured bit in bit 0.
- R6: While cfg_io_override is high, io_tck and io_tdi are held low. Data writes that target chains 0 to 3 are dropped and set the error bit.
- R7: Busy (address 3, bit 0) rises on the cycle after an accepted data write. It stays high for exactly 2*DATA_W*(DIV+1) clock cycles.
- R8: A write to address 0, 1 or 2 while busy is dropped and sets the error bit. The configuration and the shift in progress are not changed.
- R9: The error bit (address 3, bit 1) is sticky. A write to address 3 with bit 1 set clears it. A write with bit 1 clear leaves it set.
- R10: Each half period of the serial clock lasts DIV+1 clock cycles, where DIV is configuration bits [15:8]. The serial clock is low whenever busy is low.
- R11: After reset, the configuration, mode-select word, received word, busy and error all read 0, and the serial clocks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | BUS_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | BUS_W | Register read data (combinational) |
| bridge_en | input | 1 | System enable for the chain-7 bridge |
| cfg_io_override | input | 1 | FPGA port owns the I/O chains |
| ext_tck | input | 1 | External test clock pin |
| ext_tms | input | 1 | External mode select pin |
| ext_tdi | input | 1 | External test data in pin |
| ext_tdo | output | 1 | External test data out pin |
| io_tck | output | 4 | Serial clock per I/O chain |
| io_tdi | output | 4 | Serial data per I/O chain |
| tap_tck | output | 1 | Test clock to FPGA port |
| tap_tms | output | 1 | Mode select to FPGA port |
| tap_tdi | output | 1 | Test data to FPGA port |
| tap_tdo | input | 1 | Test data from FPGA port |

## Verification
The hardest case to reach is a write that lands while a shift is still running. It has to change neither the configuration nor the word on the wire, and it must leave the received bits intact. The bench starts a slow shift with a large divider and issues configuration and data writes partway through it. It then rebuilds the transmitted word from the chain pins and reads the configuration back. The receive path is driven through an inverting loopback on tap_tdo, so the word read back differs from the word sent and a wrong capture edge or bit order shows up.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int SEL_W    = 3;
  localparam int NUM_IO   = 4;
  localparam int DIV_LSB  = 8;
  localparam logic [SEL_W-1:0] TAP_SEL = 3'd7;
  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_TMS  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/srs_tck_div.sv
module srs_tck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tck_q, tck_d;
  logic             hit;

  always_comb begin
    hit   = run && (cnt_q == div);
    cnt_d = cnt_q;
    tck_d = tck_q;
    if (!run) begin
      cnt_d = '0;
      tck_d = 1'b0;
    end else if (hit) begin
      cnt_d = '0;
      tck_d = ~tck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tck_q <= tck_d;
    end
  end

  assign tck  = tck_q;
  assign rise = hit & ~tck_q;
  assign fall = hit & tck_q;

  AST_TCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !tck_q); // R10
endmodule

// File: rtl/srs_shifter.sv
module srs_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [DATA_W-1:0] tms_word,
  input  logic              rise,
  input  logic              fall,
  input  logic              tdo,
  output logic              busy,
  output logic              tdi,
  output logic              tms,
  output logic [DATA_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] dat_q, dat_d, tms_q, tms_d, rx_q, rx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;

  always_comb begin
    dat_d  = dat_q;
    tms_d  = tms_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      dat_d  = tx_word;
      tms_d  = tms_word;
      cnt_d  = CNT_W'(DATA_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (rise) rx_d = {tdo, rx_q[DATA_W-1:1]};
      if (fall) begin
        dat_d = dat_q >> 1;
        tms_d = tms_q >> 1;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      tms_q  <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      dat_q  <= dat_d;
      tms_q  <= tms_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign tdi     = dat_q[0];
  assign tms     = tms_q[0];
  assign rx_word = rx_q;

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy_q && !fall |=> busy_q); // R7
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) busy_q && !fall && !start |=> $stable(dat_q[0])); // R2
endmodule

// File: rtl/srs_router.sv
module srs_router #(
  parameter int NUM_IO = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              busy,
  input  logic              tck,
  input  logic              tdi,
  input  logic              tms,
  input  logic              bridge_en,
  input  logic              cfg_io_override,
  input  logic              ext_tck,
  input  logic              ext_tms,
  input  logic              ext_tdi,
  output logic              ext_tdo,
  output logic [NUM_IO-1:0] io_tck,
  output logic [NUM_IO-1:0] io_tdi,
  output logic              tap_tck,
  output logic              tap_tms,
  output logic              tap_tdi,
  input  logic              tap_tdo
);
  import srs_pkg::*;

  logic tap_own;

  for (genvar g = 0; g < NUM_IO; g++) begin : g_io
    logic own;
    assign own       = busy && (sel == SEL_W'(g)) && !cfg_io_override;
    assign io_tck[g] = own & tck;
    assign io_tdi[g] = own & tdi;
  end

  assign tap_own = busy && (sel == TAP_SEL);
  assign tap_tck = bridge_en ? (tap_own & tck) : ext_tck;
  assign tap_tms = bridge_en ? (tap_own & tms) : ext_tms;
  assign tap_tdi = bridge_en ? (tap_own & tdi) : ext_tdi;
  assign ext_tdo = tap_tdo;

  AST_OVERRIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_io_override |-> (io_tck == '0) && (io_tdi == '0)); // R6
  AST_UNCONNECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > SEL_W'(NUM_IO - 1)) && (sel != TAP_SEL) |-> (io_tck == '0) && !(bridge_en && tap_tck)); // R1
endmodule

// File: rtl/scan_route_ser.sv
module scan_route_ser #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int BUS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  input  logic             bridge_en,
  input  logic             cfg_io_override,
  input  logic             ext_tck,
  input  logic             ext_tms,
  input  logic             ext_tdi,
  output logic             ext_tdo,
  output logic [3:0]       io_tck,
  output logic [3:0]       io_tdi,
  output logic             tap_tck,
  output logic             tap_tms,
  output logic             tap_tdi,
  input  logic             tap_tdo
);
  import srs_pkg::*;

  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] tms_q, tms_d;
  logic              err_q, err_d;
  logic              busy, tck, rise, fall, sh_tdi, sh_tms;
  logic [DATA_W-1:0] rx_word;
  logic              wr_cfg, wr_dat, wr_tms, wr_stat, chain_ok, start, drop;

  assign wr_cfg   = wr_en && (wr_addr == A_CFG);
  assign wr_dat   = wr_en && (wr_addr == A_DATA);
  assign wr_tms   = wr_en && (wr_addr == A_TMS);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign chain_ok = ((sel_q < SEL_W'(NUM_IO)) && !cfg_io_override) ||
                    ((sel_q == TAP_SEL) && bridge_en);
  assign start    = wr_dat && !busy && chain_ok;
  assign drop     = (busy && (wr_cfg || wr_dat || wr_tms)) || (wr_dat && !busy && !chain_ok);

  always_comb begin
    sel_d = sel_q;
    div_d = div_q;
    tms_d = tms_q;
    err_d = err_q;
    if (wr_cfg && !busy) begin
      sel_d = wr_data[SEL_W-1:0];
      div_d = wr_data[DIV_LSB +: DIV_W];
    end
    if (wr_tms && !busy) tms_d = wr_data[DATA_W-1:0];
    if (drop)                      err_d = 1'b1;
    else if (wr_stat && wr_data[1]) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      div_q <= '0;
      tms_q <= '0;
      err_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      div_q <= div_d;
      tms_q <= tms_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CFG: begin
        rd_data[SEL_W-1:0]         = sel_q;
        rd_data[DIV_LSB +: DIV_W]  = div_q;
      end
      A_DATA:  rd_data[DATA_W-1:0] = rx_word;
      A_TMS:   rd_data[DATA_W-1:0] = tms_q;
      default: rd_data[1:0]        = {err_q, busy};
    endcase
  end

  srs_tck_div #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .tck(tck), .rise(rise), .fall(fall)
  );

  srs_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(wr_data[DATA_W-1:0]),
    .tms_word(tms_q), .rise(rise), .fall(fall), .tdo(tap_tdo),
    .busy(busy), .tdi(sh_tdi), .tms(sh_tms), .rx_word(rx_word)
  );

  srs_router #(.NUM_IO(NUM_IO), .SEL_W(SEL_W)) i_route (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .busy(busy), .tck(tck),
    .tdi(sh_tdi), .tms(sh_tms), .bridge_en(bridge_en),
    .cfg_io_override(cfg_io_override), .ext_tck(ext_tck), .ext_tms(ext_tms),
    .ext_tdi(ext_tdi), .ext_tdo(ext_tdo), .io_tck(io_tck), .io_tdi(io_tdi),
    .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_tdo(tap_tdo)
  );

  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr == A_DATA) && busy |=> err_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(wr_en && (wr_addr == A_STAT) && wr_data[1]) |=> err_q); // R9
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && (wr_addr == A_DATA))); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_q) && $stable(div_q)); // R8
endmodule

// File: tb/test_scan_route_ser.sv
module test_scan_route_ser;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int BUS_W  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [BUS_W-1:0] wr_data = '0;
  logic [1:0]       rd_addr = 2'd3;
  logic [BUS_W-1:0] rd_data;
  logic             bridge_en = 1'b0, cfg_io_override = 1'b0;
  logic             ext_tck = 1'b0, ext_tms = 1'b0, ext_tdi = 1'b0;
  logic             ext_tdo;
  logic [3:0]       io_tck, io_tdi;
  logic             tap_tck, tap_tms, tap_tdi, tap_tdo;
  logic             inv = 1'b0;
  logic             ext_tdo_drv = 1'b0;

  assign tap_tdo = bridge_en ? (tap_tdi ^ inv) : ext_tdo_drv;

  scan_route_ser #(.DATA_W(DATA_W), .DIV_W(DIV_W), .BUS_W(BUS_W)) i_scan_route_ser (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bridge_en(bridge_en),
    .cfg_io_override(cfg_io_override), .ext_tck(ext_tck), .ext_tms(ext_tms),
    .ext_tdi(ext_tdi), .ext_tdo(ext_tdo), .io_tck(io_tck), .io_tdi(io_tdi),
    .tap_tck(tap_tck), .tap_tms(tap_tms), .tap_tdi(tap_tdi), .tap_tdo(tap_tdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;

  // pin monitors, sampled at falling clock edge
  logic [3:0]        io_prev = '0;
  logic              tap_prev = 1'b0;
  logic [DATA_W-1:0] io_cap [4];
  int                io_rises [4];
  logic [DATA_W-1:0] tap_cap_tdi = '0, tap_cap_tms = '0;
  int                tap_rises = 0;
  int                io_high = 0;

  initial for (int k = 0; k < 4; k++) begin io_cap[k] = '0; io_rises[k] = 0; end

  always @(negedge clk) begin
    cycles++;
    for (int k = 0; k < 4; k++) begin
      if (io_tck[k] && !io_prev[k]) begin
        io_cap[k] <= {io_tdi[k], io_cap[k][DATA_W-1:1]};
        io_rises[k] <= io_rises[k] + 1;
      end
    end
    if (io_tck != '0) io_high <= io_high + 1;
    if (bridge_en && tap_tck && !tap_prev) begin
      tap_cap_tdi <= {tap_tdi, tap_cap_tdi[DATA_W-1:1]};
      tap_cap_tms <= {tap_tms, tap_cap_tms[DATA_W-1:1]};
      tap_rises <= tap_rises + 1;
    end
    io_prev  <= io_tck;
    tap_prev <= tap_tck;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [BUS_W-1:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
    rd_addr = 2'd3;
  endtask

  // counts falling edges with busy high, starting right after a data write
  task automatic wait_idle(output int n);
    n = 0;
    rd_addr = 2'd3;
    #1;
    while (rd_data[0]) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic cfg_word(input int sel, input int dv, output logic [BUS_W-1:0] w);
    w = BUS_W'((dv << 8) | sel);
  endtask

  task automatic t_reset;
    logic [BUS_W-1:0] v;
    rd(2'd0, v); check(v == 0, "R11 cfg", v, 0);
    rd(2'd3, v); check(v == 0, "R11 status", v, 0);
    rd(2'd1, v); check(v == 0, "R11 rx", v, 0);
    rd(2'd2, v); check(v == 0, "R11 tms", v, 0);
    check(io_tck == 0, "R11 io_tck", io_tck, 0);
  endtask

  task automatic t_io_shift(input int ch, input int dv, input logic [DATA_W-1:0] word);
    logic [BUS_W-1:0] w;
    int n, r0[4], h0;
    cfg_word(ch, dv, w);
    wr(2'd0, w);
    for (int k = 0; k < 4; k++) r0[k] = io_rises[k];
    h0 = io_high;
    wr(2'd1, BUS_W'(word));
    wait_idle(n);
    repeat (2) @(negedge clk);
    check(n == 2*DATA_W*(dv+1), "R7 busy length", n, 2*DATA_W*(dv+1));
    check(io_high - h0 == DATA_W*(dv+1), "R10 high time", io_high - h0, DATA_W*(dv+1));
    check(io_cap[ch] == word, "R2 word on chain", io_cap[ch], word);
    for (int k = 0; k < 4; k++)
      check(io_rises[k] - r0[k] == ((k == ch) ? DATA_W : 0), "R2 clock count per chain",
            io_rises[k] - r0[k], (k == ch) ? DATA_W : 0);
    check(io_tck == 0, "R10 idle low", io_tck, 0);
  endtask

  task automatic t_tap_shift;
    logic [BUS_W-1:0] w, v;
    int n, r0;
    bridge_en = 1'b1; inv = 1'b1;
    cfg_word(7, 1, w);
    wr(2'd0, w);
    wr(2'd2, 16'h0096);
    r0 = tap_rises;
    wr(2'd1, 16'h00C5);
    wait_idle(n);
    repeat (2) @(negedge clk);
    check(tap_rises - r0 == DATA_W, "R3 tap clock count", tap_rises - r0, DATA_W);
    check(tap_cap_tdi == 8'hC5, "R3 tap data", tap_cap_tdi, 8'hC5);
    check(tap_cap_tms == 8'h96, "R3 tap mode select", tap_cap_tms, 8'h96);
    rd(2'd1, v);
    check(v[DATA_W-1:0] == 8'h3A, "R5 received word", v, 8'h3A);
    inv = 1'b0;
    bridge_en = 1'b0;
  endtask

  task automatic t_bridge_off;
    logic [BUS_W-1:0] w, v;
    int r0;
    bridge_en = 1'b0;
    cfg_word(7, 0, w);
    wr(2'd0, w);
    wr(2'd3, 16'h0002);
    r0 = tap_rises;
    wr(2'd1, 16'h00FF);
    rd(2'd3, v);
    check(v[1:0] == 2'b10, "R4 drop with bridge off", v, 2);
    ext_tck = 1'b1; ext_tms = 1'b1; ext_tdi = 1'b0; ext_tdo_drv = 1'b1;
    #1;
    check({tap_tck, tap_tms, tap_tdi} == 3'b110, "R4 pins pass through", {tap_tck, tap_tms, tap_tdi}, 3'b110);
    check(ext_tdo == 1'b1, "R4 tdo pass", ext_tdo, 1);
    ext_tck = 1'b0; ext_tms = 1'b0; ext_tdo_drv = 1'b0;
    check(tap_rises == r0, "R4 no bridged clocks", tap_rises, r0);
  endtask

  task automatic t_unconnected;
    logic [BUS_W-1:0] w, v;
    int r0[4], t0;
    bridge_en = 1'b1;
    wr(2'd3, 16'h0002);
    cfg_word(5, 0, w);
    wr(2'd0, w);
    for (int k = 0; k < 4; k++) r0[k] = io_rises[k];
    t0 = tap_rises;
    wr(2'd1, 16'h00AA);
    repeat (40) @(negedge clk);
    rd(2'd3, v);
    check(v[1:0] == 2'b10, "R1 drop on index 5", v, 2);
    check(io_rises[0] + io_rises[1] + io_rises[2] + io_rises[3] == r0[0] + r0[1] + r0[2] + r0[3] && tap_rises == t0,
          "R1 nothing driven", tap_rises, t0);
    bridge_en = 1'b0;
  endtask

  task automatic t_override;
    logic [BUS_W-1:0] w, v;
    int r1;
    wr(2'd3, 16'h0002);
    cfg_io_override = 1'b1;
    cfg_word(1, 0, w);
    wr(2'd0, w);
    r1 = io_rises[1];
    wr(2'd1, 16'h0055);
    repeat (40) @(negedge clk);
    rd(2'd3, v);
    check(v[1:0] == 2'b10, "R6 drop under override", v, 2);
    check(io_rises[1] == r1 && io_tck == 0 && io_tdi == 0, "R6 chains quiet", io_rises[1], r1);
    cfg_io_override = 1'b0;
  endtask

  task automatic t_write_while_busy;
    logic [BUS_W-1:0] w, v;
    int n;
    wr(2'd3, 16'h0002);
    cfg_word(3, 3, w);
    wr(2'd0, w);
    wr(2'd1, 16'h00B4);
    repeat (10) @(negedge clk);
    cfg_word(0, 0, w);
    wr(2'd0, w);
    wr(2'd1, 16'h00FF);
    wr(2'd2, 16'h00FF);
    wait_idle(n);
    repeat (2) @(negedge clk);
    check(io_cap[3] == 8'hB4, "R8 shift not disturbed", io_cap[3], 8'hB4);
    rd(2'd0, v);
    check(v == 16'h0303, "R8 cfg unchanged", v, 16'h0303);
    rd(2'd2, v);
    check(v[DATA_W-1:0] == 8'h96, "R8 tms unchanged", v, 8'h96);
    rd(2'd3, v);
    check(v[1] == 1'b1, "R8 error set", v, 2);
  endtask

  task automatic t_err_clear;
    logic [BUS_W-1:0] v;
    wr(2'd3, 16'h0001);
    rd(2'd3, v);
    check(v[1] == 1'b1, "R9 stays set", v, 2);
    wr(2'd3, 16'h0002);
    rd(2'd3, v);
    check(v[1] == 1'b0, "R9 cleared", v, 0);
  endtask

  initial begin
    while (cycles < 100000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_io_shift(0, 0, 8'hA5);
    t_io_shift(2, 3, 8'h3C);
    t_tap_shift();
    t_bridge_off();
    t_unconnected();
    t_override();
    t_write_while_busy();
    t_err_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule